// File: doc/BRIEF.md
# RGMII Receive Sampling Adjuster

This block retimes the five RGMII receive lines (the receive control line and the four data lines) in a fast timing-adjustment clock domain before they reach the MAC. The receive clock is brought into the fast domain, and both of its edges are detected there. A counter in the fast domain restarts at every receive-clock edge. Each line is captured when the counter reaches a target value. That target comes from a programmed delay, or, in automatic mode, from half of the previously measured half-period. A per-line skew mask can push a single line's capture one fast cycle later, which stands for roughly 1 ns of extra pad delay.

When adjustment is disabled, the block works as a plain sampler. The line values seen when a receive-clock edge is detected are forwarded directly. Results from the half-period that follows a rising edge go to the rise outputs. Results from the half-period that follows a falling edge go to the fall outputs. A strobe marks each completed receive-clock period. If the programmed delay falls beyond the end of a half-period, the lines are not captured in time. That half's result is then dropped, and a sticky error flag is raised.

Top module: `rgmii_rx_sample_adj`

## Requirements
- R1: While reset is asserted and after it is released (with no receive-clock activity), every data and control output, `sample_valid` and `overrun` are 0.
- R2: The receive clock and the five lines pass through two fast-clock flops each. With `cfg_enable`=0 the block forwards, at each detected receive-clock edge, the line values that were present at the same fast-clock edge at which the receive-clock transition was first sampled.
- R3: With `cfg_enable`=1 and `cfg_auto`=0, a line with its skew bit clear takes the value present k+1 fast-clock edges after the fast edge that first sampled the receive-clock transition, where k = `cfg_delay`. The counter behind this restarts at every receive-clock edge and saturates at 31.
- R4: Skew bit mapping: bit 0 = receive control, bit 1 = data[3], bit 2 = data[2], bit 3 = data[1], bit 4 = data[0]. A set bit captures that line one fast cycle later than its unskewed neighbours (index k+2).
- R5: A capture index equal to the half-period length L, in fast cycles, is legal. The value it takes is the one present at the first fast edge of the following half.
- R6: With `cfg_enable`=1 and `cfg_auto`=1, k = floor(min(L-1, 31) / 2), where L is the length of the previous half-period. The skew mask is ignored in this mode. With `cfg_enable`=0, `cfg_auto` has no effect.
- R7: Values from the half after a rising edge appear on `rise_ctl`/`rise_data`. Values from the half after a falling edge appear on `fall_ctl`/`fall_data`. The data bit positions on these outputs match the input pins.
- R8: `sample_valid` is a one-cycle pulse, issued once per receive-clock period, in the cycle in which new fall outputs appear. The rise outputs then hold the rise half of the same period.
- R9: If any line is not captured by the end of its half-period, that half publishes nothing: the outputs stay unchanged and no strobe is issued. `overrun` is then set. It stays set until reset, and it is never set while `cfg_enable`=0.
- R10: The first half-period after reset, or after adjustment is switched on, is not published, and it cannot set `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing-adjustment clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | 1 selects the adjusted path, 0 selects direct sampling |
| cfg_auto | input | 1 | 1 derives the delay from the measured half-period |
| cfg_delay | input | CNT_W | Programmed capture count after each edge |
| cfg_skew | input | 5 | Per-line one-cycle extra delay mask |
| rx_clk_pin | input | 1 | Receive clock from the pad |
| rx_ctl_pin | input | 1 | Receive control line from the pad |
| rx_data_pin | input | 4 | Receive data lines from the pad |
| rise_data | output | 4 | Data captured in the half after a rising edge |
| rise_ctl | output | 1 | Control captured in the half after a rising edge |
| fall_data | output | 4 | Data captured in the half after a falling edge |
| fall_ctl | output | 1 | Control captured in the half after a falling edge |
| sample_valid | output | 1 | One-cycle strobe per completed receive-clock period |
| overrun | output | 1 | Sticky flag for a missed capture |

## Verification
A counter or measured half-length that is off by one shows at the ports within a single receive-clock period. It appears as a neighbouring value of the per-cycle ramp driven on the lines, and each line can be told apart through the skew mask. A wrong edge phase swaps the rise and fall nibbles at the very next strobe. A stale per-line capture flag either loses the strobe or raises `overrun` at the end of the affected half. The sticky flag and the strobe count are therefore checked after every configuration change.

// File: rtl/rgmii_rx_sample_adj.sv
module rgmii_rx_sample_adj #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_auto,
  input  logic [CNT_W-1:0] cfg_delay,
  input  logic [4:0]       cfg_skew,
  input  logic             rx_clk_pin,
  input  logic             rx_ctl_pin,
  input  logic [3:0]       rx_data_pin,
  output logic [3:0]       rise_data,
  output logic             rise_ctl,
  output logic [3:0]       fall_data,
  output logic             fall_ctl,
  output logic             sample_valid,
  output logic             overrun
);

  localparam int LINES = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0]       rxc_sync;
  logic             rxc_q;
  logic [LINES-1:0] pin_vec, pin_m, pin_s;
  logic [CNT_W-1:0] cnt, half_len, base_tgt;
  logic [LINES-1:0] eff_skew, got, hit, stg, merged, rise_q, fall_q;
  logic             half_rise, primed, all_done, edge_any, edge_rise;

  assign pin_vec   = {rx_data_pin[0], rx_data_pin[1], rx_data_pin[2], rx_data_pin[3], rx_ctl_pin};
  assign edge_any  = rxc_sync[1] ^ rxc_q;
  assign edge_rise = rxc_sync[1] & ~rxc_q;
  assign base_tgt  = cfg_auto ? (half_len >> 1) : cfg_delay;
  assign eff_skew  = cfg_auto ? '0 : cfg_skew;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [CNT_W:0] tgt;
      assign tgt       = {1'b0, base_tgt} + {{CNT_W{1'b0}}, eff_skew[i]};
      assign hit[i]    = ~got[i] & ({1'b0, cnt} == tgt);
      assign merged[i] = got[i] ? stg[i] : pin_s[i];
    end
  endgenerate

  assign all_done = &(got | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_sync     <= '0;
      rxc_q        <= 1'b0;
      pin_m        <= '0;
      pin_s        <= '0;
      cnt          <= '0;
      half_len     <= '0;
      half_rise    <= 1'b0;
      primed       <= 1'b0;
      got          <= '0;
      stg          <= '0;
      rise_q       <= '0;
      fall_q       <= '0;
      sample_valid <= 1'b0;
      overrun      <= 1'b0;
    end else begin
      rxc_sync     <= {rxc_sync[0], rx_clk_pin};
      rxc_q        <= rxc_sync[1];
      pin_m        <= pin_vec;
      pin_s        <= pin_m;
      sample_valid <= 1'b0;
      if (edge_any) begin
        cnt       <= '0;
        half_len  <= cnt;
        half_rise <= edge_rise;
        got       <= '0;
        if (!cfg_enable) begin
          primed <= 1'b0;
          if (edge_rise) rise_q <= pin_s;
          else begin
            fall_q       <= pin_s;
            sample_valid <= 1'b1;
          end
        end else begin
          primed <= 1'b1;
          if (primed) begin
            if (all_done) begin
              if (half_rise) rise_q <= merged;
              else begin
                fall_q       <= merged;
                sample_valid <= 1'b1;
              end
            end else begin
              overrun <= 1'b1;
            end
          end
        end
      end else begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cfg_enable) begin
          got <= got | hit;
          stg <= (stg & ~hit) | (pin_s & hit);
        end
      end
    end
  end

  assign rise_ctl  = rise_q[0];
  assign rise_data = {rise_q[1], rise_q[2], rise_q[3], rise_q[4]};
  assign fall_ctl  = fall_q[0];
  assign fall_data = {fall_q[1], fall_q[2], fall_q[3], fall_q[4]};

endmodule

// File: rtl/rgmii_rx_sample_adj_chk.sv
module rgmii_rx_sample_adj_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_enable,
  input logic       sample_valid,
  input logic       overrun,
  input logic [3:0] fall_data,
  input logic       fall_ctl
);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_fall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable({fall_ctl, fall_data}));

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_overrun_adjust_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(cfg_enable));

  assert_overrun_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !sample_valid);

endmodule

bind rgmii_rx_sample_adj rgmii_rx_sample_adj_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cfg_enable(cfg_enable),
  .sample_valid(sample_valid),
  .overrun(overrun),
  .fall_data(fall_data),
  .fall_ctl(fall_ctl)
);

// File: tb/rgmii_rx_sample_adj_bench.sv
module rgmii_rx_sample_adj_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0;
  logic       cfg_auto = 1'b0;
  logic [4:0] cfg_delay = '0;
  logic [4:0] cfg_skew = '0;
  logic       rx_clk_pin = 1'b0;
  logic       rx_ctl_pin = 1'b0;
  logic [3:0] rx_data_pin = '0;
  logic [3:0] rise_data, fall_data;
  logic       rise_ctl, fall_ctl, sample_valid, overrun;

  int checks = 0;
  int errors = 0;
  int vcount = 0;

  always #10 clk = ~clk;

  rgmii_rx_sample_adj u_rgmii_rx_sample_adj (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_auto(cfg_auto),
    .cfg_delay(cfg_delay), .cfg_skew(cfg_skew), .rx_clk_pin(rx_clk_pin),
    .rx_ctl_pin(rx_ctl_pin), .rx_data_pin(rx_data_pin), .rise_data(rise_data),
    .rise_ctl(rise_ctl), .fall_data(fall_data), .fall_ctl(fall_ctl),
    .sample_valid(sample_valid), .overrun(overrun)
  );

  typedef struct packed {
    logic       en;
    logic       au;
    logic [4:0] dly;
    logic [4:0] skw;
    logic [7:0] len;
    logic [4:0] seed;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 5'd0, 5'h00, 8'd8,  5'h0A},
    '{1'b0, 1'b1, 5'd9, 5'h1F, 8'd12, 5'h13},
    '{1'b1, 1'b0, 5'd0, 5'h00, 8'd8,  5'h05},
    '{1'b1, 1'b0, 5'd3, 5'h00, 8'd10, 5'h1C},
    '{1'b1, 1'b0, 5'd5, 5'h15, 8'd10, 5'h07},
    '{1'b1, 1'b0, 5'd2, 5'h1F, 8'd8,  5'h11},
    '{1'b1, 1'b0, 5'd7, 5'h00, 8'd8,  5'h02},
    '{1'b1, 1'b0, 5'd6, 5'h01, 8'd8,  5'h19},
    '{1'b1, 1'b1, 5'd0, 5'h1F, 8'd12, 5'h0E},
    '{1'b1, 1'b1, 5'd9, 5'h00, 8'd9,  5'h15},
    '{1'b1, 1'b1, 5'd0, 5'h00, 8'd80, 5'h0B}
  };

  function automatic logic [4:0] pat(input logic rise, input logic [4:0] seed, input int j);
    return rise ? 5'(seed + 5'(3 * j)) : 5'(~seed + 5'(5 * j));
  endfunction

  function automatic logic [4:0] exp_vec(input vec_t v, input logic rise);
    logic [4:0] e;
    for (int i = 0; i < 5; i++) begin
      int s;
      int h;
      logic [4:0] val;
      h = (int'(v.len) - 1 > 31) ? 31 : int'(v.len) - 1;
      if (!v.en) s = 0;
      else if (v.au) s = (h / 2) + 1;
      else s = int'(v.dly) + 1 + int'(v.skw[i]);
      val = (s < int'(v.len)) ? pat(rise, v.seed, s) : pat(!rise, v.seed, s - int'(v.len));
      e[i] = val[i];
    end
    return e;
  endfunction

  function automatic logic [4:0] out_rise();
    return {rise_data[0], rise_data[1], rise_data[2], rise_data[3], rise_ctl};
  endfunction

  function automatic logic [4:0] out_fall();
    return {fall_data[0], fall_data[1], fall_data[2], fall_data[3], fall_ctl};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic run_half(input logic rise, input int len, input logic [4:0] seed);
    for (int j = 0; j < len; j++) begin
      logic [4:0] pv;
      @(negedge clk);
      pv = pat(rise, seed, j);
      rx_clk_pin  = rise;
      rx_ctl_pin  = pv[0];
      rx_data_pin = {pv[1], pv[2], pv[3], pv[4]};
    end
  endtask

  task automatic run_period(input int len, input logic [4:0] seed);
    run_half(1'b1, len, seed);
    run_half(1'b0, len, seed);
  endtask

  always @(negedge clk) if (rst_n && sample_valid) vcount++;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    logic [4:0] er, ef;
    repeat (4) @(negedge clk);
    chk(out_rise() == 0 && out_fall() == 0, "R1 outputs in reset", {out_rise(), out_fall()}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(out_rise() == 0 && out_fall() == 0, "R1 outputs after reset", {out_rise(), out_fall()}, 0);
    chk(sample_valid == 0 && overrun == 0, "R1 flags after reset", {sample_valid, overrun}, 0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      cfg_enable = 1'b0;
      cfg_auto   = v.au;
      cfg_delay  = v.dly;
      cfg_skew   = v.skw;
      run_period(int'(v.len), v.seed);
      cfg_enable = v.en;
      #1;
      base = vcount;
      for (int p = 0; p < 3; p++) run_period(int'(v.len), v.seed);
      run_half(1'b1, int'(v.len), v.seed);
      #1;
      er = exp_vec(v, 1'b1);
      ef = exp_vec(v, 1'b0);
      // R2 R3 R4 R5 R6 R7 depending on the vector; strobe count covers R8 R10
      chk(out_rise() == er, v.en ? (v.au ? "R6 R7 rise" : "R3 R4 R5 R7 rise") : "R2 R6 R7 rise",
          out_rise(), er);
      chk(out_fall() == ef, v.en ? (v.au ? "R6 R7 fall" : "R3 R4 R5 R7 fall") : "R2 R6 R7 fall",
          out_fall(), ef);
      chk(vcount - base == 3, v.en ? "R8 R10 strobe count" : "R8 strobe count", vcount - base, 3);
      chk(overrun == 1'b0, "R9 no overrun", overrun, 0);
      run_half(1'b0, int'(v.len), v.seed);
    end

    cfg_enable = 1'b0;
    cfg_auto   = 1'b0;
    cfg_delay  = 5'd20;
    cfg_skew   = 5'h00;
    run_period(8, 5'h06);
    chk(overrun == 1'b0, "R9 bypass never sets overrun", overrun, 0);
    cfg_enable = 1'b1;
    #1;
    base = vcount;
    for (int p = 0; p < 3; p++) run_period(8, 5'h06);
    run_half(1'b1, 8, 5'h06);
    #1;
    chk(overrun == 1'b1, "R9 overrun set", overrun, 1);
    chk(vcount - base == 0, "R9 no strobe on overrun", vcount - base, 0);
    chk(out_rise() == pat(1'b1, 5'h06, 0), "R9 rise unchanged", out_rise(), pat(1'b1, 5'h06, 0));
    chk(out_fall() == pat(1'b0, 5'h06, 0), "R9 fall unchanged", out_fall(), pat(1'b0, 5'h06, 0));
    cfg_enable = 1'b0;
    run_half(1'b0, 8, 5'h06);
    #1;
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(overrun == 1'b0, "R1 R9 overrun cleared by reset", overrun, 0);
    chk(out_rise() == 0 && out_fall() == 0, "R1 outputs cleared by reset", {out_rise(), out_fall()}, 0);
    chk(sample_valid == 1'b0, "R1 strobe low after reset", sample_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule